// File: doc/BRIEF.md
# JTAG Test Access Port Controller

This block is the test access port of a chip's boundary-scan logic. It receives a test clock, a mode-select line, serial data in and an optional active-low asynchronous reset. It drives a serial data output together with its output enable, so the pad can float when nothing is being shifted. Inside are the sixteen-state port controller, a four-bit instruction register, a one-bit bypass register and a 32-bit identification register. It also has a strobe and serial interface to a boundary-scan register that lives outside the block.

The active instruction picks which data register sits between serial input and output. From the same decode the block produces one merged mode signal. It tells the core whether its I/O comes from the pins or from the boundary-scan path. TMS and TDI are sampled on the rising test-clock edge. The output and its enable are updated on the falling edge, so the next device in a daisy chain gets half a period of setup time. Board-level pull-ups on TMS, TDI and the reset line make open inputs read as logic 1. With those pull-ups, a floating TMS drives the controller to its reset state.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The controller follows the standard sixteen-state sequence on rising TCK edges. It stays in Test-Logic-Reset while TMS is 1, and five consecutive rising edges with TMS at 1 reach Test-Logic-Reset from any state.
- R2: Driving trst_ni low puts the controller in Test-Logic-Reset at once, without waiting for a clock edge. It also makes IDCODE the active instruction (so mode_o is 0) and deasserts tdo_oe_o.
- R3: The instruction register is 4 bits wide. In Capture-IR it loads 4'b0001. In Shift-IR it shifts least significant bit first: TDI enters at the top and bit 0 drives TDO.
- R4: The active instruction changes only on the rising edge taken in Update-IR, or when the controller is in Test-Logic-Reset, which loads IDCODE. Shifting alone leaves mode_o unchanged.
- R5: The opcodes are EXTEST 4'b0000, SAMPLE 4'b0010, IDCODE 4'b0011 and INTEST 4'b0100. BYPASS is 4'b1111, and every other code also acts as BYPASS.
- R6: Under BYPASS, the data path is one bit long. It captures 0 in Capture-DR, so TDO shows 0 first and then TDI delayed by one shift.
- R7: Under IDCODE, the 32-bit parameter value is captured in Capture-DR and shifted out least significant bit first.
- R8: Under SAMPLE, EXTEST and INTEST, TDO follows bsr_so_i in Shift-DR. In those states bsr_capture_o, bsr_shift_o and bsr_update_o are high during Capture-DR, Shift-DR and Update-DR respectively. They stay low under any other instruction, and no two are high at once.
- R9: mode_o is 1 while EXTEST or INTEST is active and 0 for every other instruction.
- R10: tdo_o and tdo_oe_o change only on falling TCK edges. tdo_oe_o is 1 only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| tms_i | input | 1 | Test mode select, sampled on rising edge |
| tdi_i | input | 1 | Serial test data in, sampled on rising edge |
| trst_ni | input | 1 | Asynchronous active-low port reset |
| tdo_o | output | 1 | Serial test data out, updated on falling edge |
| tdo_oe_o | output | 1 | Output enable for the TDO pad |
| mode_o | output | 1 | 1: core I/O taken from the scan path; 0: from the pins |
| bsr_si_o | output | 1 | Serial input to the external boundary-scan register |
| bsr_so_i | input | 1 | Serial output of the external boundary-scan register |
| bsr_capture_o | output | 1 | Capture strobe for the boundary-scan register |
| bsr_shift_o | output | 1 | Shift enable for the boundary-scan register |
| bsr_update_o | output | 1 | Update strobe for the boundary-scan register |

## Verification
The assertions assume that TMS and TDI are stable around each rising TCK edge. They also assume that reset is released away from a rising edge, so each sampled value is the one the bench meant. The bench changes TMS, TDI and bsr_so_i only just after a falling edge. It releases reset the same way. It reads TDO just after the falling edge and again just after the rising edge, to show that the rising edge leaves it unchanged. The bench holds bsr_so_i steady through each falling edge in Shift-DR, because the falling edge is where the block samples it.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DSEL_BYP,
        DSEL_ID,
        DSEL_BSR
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0010;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0011;
    localparam logic [IR_W-1:0] OP_INTEST  = 4'b0100;
    localparam logic [IR_W-1:0] OP_BYPASS  = {IR_W{1'b1}};
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            TS_RESET:  n = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   n = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: n = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: n = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  n = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: n = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: n = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: n = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: n = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: n = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: n = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  n = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: n = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: n = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: n = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: n = tms ? TS_SEL_DR : TS_IDLE;
            default:   n = TS_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck_i,
    input  logic       trst_ni,
    input  logic       tms_i,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.st = tap_next(s_q.st, tms_i);
    end

    always_ff @(posedge tck_i or negedge trst_ni) begin
        if (!trst_ni) s_q <= '{st: TS_RESET};
        else          s_q <= s_d;
    end

    assign state_o = s_q.st;

    // Run length of TMS-high edges, saturating at five (checker state only).
    logic [2:0] ones_q;
    always_ff @(posedge tck_i or negedge trst_ni) begin
        if (!trst_ni)          ones_q <= 3'd0;
        else if (!tms_i)       ones_q <= 3'd0;
        else if (ones_q < 3'd5) ones_q <= ones_q + 3'd1;
    end

    // R1
    tlr_hold_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (s_q.st == TS_RESET && tms_i) |=> s_q.st == TS_RESET);

    // R1
    five_ones_reset_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (ones_q == 3'd5) |-> s_q.st == TS_RESET);

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic       tck_i,
    input  logic       trst_ni,
    input  logic       tdi_i,
    input  tap_state_e state_i,
    output logic       ir_so_o,
    output dr_sel_e    sel_o,
    output logic       mode_o
);

    typedef struct packed {
        logic [IR_W-1:0] sr;
        logic [IR_W-1:0] act;
    } ir_t;

    ir_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state_i)
            TS_RESET:  r_d.act = OP_IDCODE;
            TS_CAP_IR: r_d.sr  = IR_CAPTURE;
            TS_SH_IR:  r_d.sr  = {tdi_i, r_q.sr[IR_W-1:1]};
            TS_UPD_IR: r_d.act = r_q.sr;
            default: ;
        endcase
    end

    always_ff @(posedge tck_i or negedge trst_ni) begin
        if (!trst_ni) r_q <= '{sr: IR_CAPTURE, act: OP_IDCODE};
        else          r_q <= r_d;
    end

    always_comb begin
        case (r_q.act)
            OP_EXTEST, OP_SAMPLE, OP_INTEST: sel_o = DSEL_BSR;
            OP_IDCODE:                       sel_o = DSEL_ID;
            default:                         sel_o = DSEL_BYP;
        endcase
    end

    assign mode_o  = (r_q.act == OP_EXTEST) || (r_q.act == OP_INTEST);
    assign ir_so_o = r_q.sr[0];

    // R3
    ir_capture_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (state_i == TS_CAP_IR) |=> r_q.sr == IR_CAPTURE);

    // R4
    ir_hold_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (state_i != TS_UPD_IR && state_i != TS_RESET) |=> $stable(r_q.act));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int              ID_W   = 32,
    parameter logic [ID_W-1:0] ID_VAL = 32'h1357_9BDF
) (
    input  logic       tck_i,
    input  logic       trst_ni,
    input  logic       tdi_i,
    input  tap_state_e state_i,
    input  dr_sel_e    sel_i,
    input  logic       ir_so_i,
    input  logic       bsr_so_i,
    output logic       tdo_o,
    output logic       tdo_oe_o,
    output logic       bsr_capture_o,
    output logic       bsr_shift_o,
    output logic       bsr_update_o
);

    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id;
    } rise_t;

    typedef struct packed {
        logic tdo;
        logic oe;
    } fall_t;

    rise_t r_d, r_q;
    fall_t f_d, f_q;
    logic  out_bit;
    logic  in_shift;

    always_comb begin
        r_d = r_q;
        case (state_i)
            TS_CAP_DR: begin
                r_d.byp = 1'b0;
                if (sel_i == DSEL_ID) r_d.id = ID_VAL;
            end
            TS_SH_DR: begin
                r_d.byp = tdi_i;
                if (sel_i == DSEL_ID) r_d.id = {tdi_i, r_q.id[ID_W-1:1]};
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck_i or negedge trst_ni) begin
        if (!trst_ni) r_q <= '{byp: 1'b0, id: ID_VAL};
        else          r_q <= r_d;
    end

    always_comb begin
        if (state_i == TS_SH_IR) begin
            out_bit = ir_so_i;
        end else begin
            case (sel_i)
                DSEL_ID:  out_bit = r_q.id[0];
                DSEL_BSR: out_bit = bsr_so_i;
                default:  out_bit = r_q.byp;
            endcase
        end
    end

    assign in_shift = (state_i == TS_SH_IR) || (state_i == TS_SH_DR);

    always_comb begin
        f_d.tdo = out_bit;
        f_d.oe  = in_shift;
    end

    always_ff @(negedge tck_i or negedge trst_ni) begin
        if (!trst_ni) f_q <= '{tdo: 1'b0, oe: 1'b0};
        else          f_q <= f_d;
    end

    assign tdo_o         = f_q.tdo;
    assign tdo_oe_o      = f_q.oe;
    assign bsr_capture_o = (sel_i == DSEL_BSR) && (state_i == TS_CAP_DR);
    assign bsr_shift_o   = (sel_i == DSEL_BSR) && (state_i == TS_SH_DR);
    assign bsr_update_o  = (sel_i == DSEL_BSR) && (state_i == TS_UPD_DR);

    // R6
    byp_capture_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (state_i == TS_CAP_DR) |=> r_q.byp == 1'b0);

    // R10
    oe_shift_only_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        tdo_oe_o |-> (state_i == TS_SH_IR || state_i == TS_SH_DR));

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
    import jtag_tap_pkg::*;
#(
    parameter int              ID_W   = 32,
    parameter logic [ID_W-1:0] ID_VAL = 32'h1357_9BDF
) (
    input  logic tck_i,
    input  logic tms_i,
    input  logic tdi_i,
    input  logic trst_ni,
    output logic tdo_o,
    output logic tdo_oe_o,
    output logic mode_o,
    output logic bsr_si_o,
    input  logic bsr_so_i,
    output logic bsr_capture_o,
    output logic bsr_shift_o,
    output logic bsr_update_o
);

    tap_state_e state;
    dr_sel_e    sel;
    logic       ir_so;

    tap_fsm u_fsm (
        .tck_i   (tck_i),
        .trst_ni (trst_ni),
        .tms_i   (tms_i),
        .state_o (state)
    );

    tap_ir u_ir (
        .tck_i   (tck_i),
        .trst_ni (trst_ni),
        .tdi_i   (tdi_i),
        .state_i (state),
        .ir_so_o (ir_so),
        .sel_o   (sel),
        .mode_o  (mode_o)
    );

    tap_dr #(
        .ID_W   (ID_W),
        .ID_VAL (ID_VAL)
    ) u_dr (
        .tck_i         (tck_i),
        .trst_ni       (trst_ni),
        .tdi_i         (tdi_i),
        .state_i       (state),
        .sel_i         (sel),
        .ir_so_i       (ir_so),
        .bsr_so_i      (bsr_so_i),
        .tdo_o         (tdo_o),
        .tdo_oe_o      (tdo_oe_o),
        .bsr_capture_o (bsr_capture_o),
        .bsr_shift_o   (bsr_shift_o),
        .bsr_update_o  (bsr_update_o)
    );

    assign bsr_si_o = tdi_i;

    // R8
    bsr_strobe_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        $onehot0({bsr_capture_o, bsr_shift_o, bsr_update_o}));

    // R9
    mode_hold_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (mode_o && state != TS_UPD_IR && state != TS_RESET) |=> mode_o);

endmodule

// File: tb/tb_jtag_tap_ctrl.sv
module tb_jtag_tap_ctrl;
    import jtag_tap_pkg::*;

    localparam int          CLK_P = 10;
    localparam logic [31:0] IDV   = 32'h1357_9BDF;

    logic tck = 1'b0, tms = 1'b1, tdi = 1'b1, trst_n = 1'b0, bsr_so = 1'b0;
    logic tdo, tdo_oe, mode, bsr_si, bsr_cap, bsr_sh, bsr_upd;

    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;
    logic cur_mode = 1'b0;
    tap_state_e mst = TS_RESET;

    jtag_tap_ctrl dut (
        .tck_i(tck), .tms_i(tms), .tdi_i(tdi), .trst_ni(trst_n),
        .tdo_o(tdo), .tdo_oe_o(tdo_oe), .mode_o(mode),
        .bsr_si_o(bsr_si), .bsr_so_i(bsr_so),
        .bsr_capture_o(bsr_cap), .bsr_shift_o(bsr_sh), .bsr_update_o(bsr_upd)
    );

    always #(CLK_P/2) tck = ~tck;

    // Reference state model, written as a TMS-high table and a TMS-low table.
    function automatic tap_state_e ref_next(tap_state_e s, logic m);
        if (m) begin
            case (s)
                TS_IDLE, TS_UPD_DR, TS_UPD_IR:  return TS_SEL_DR;
                TS_SEL_DR:                      return TS_SEL_IR;
                TS_CAP_DR, TS_SH_DR:            return TS_EX1_DR;
                TS_EX1_DR, TS_EX2_DR:           return TS_UPD_DR;
                TS_PAU_DR:                      return TS_EX2_DR;
                TS_CAP_IR, TS_SH_IR:            return TS_EX1_IR;
                TS_EX1_IR, TS_EX2_IR:           return TS_UPD_IR;
                TS_PAU_IR:                      return TS_EX2_IR;
                default:                        return TS_RESET;
            endcase
        end else begin
            case (s)
                TS_SEL_DR:                      return TS_CAP_DR;
                TS_CAP_DR, TS_SH_DR, TS_EX2_DR: return TS_SH_DR;
                TS_EX1_DR, TS_PAU_DR:           return TS_PAU_DR;
                TS_SEL_IR:                      return TS_CAP_IR;
                TS_CAP_IR, TS_SH_IR, TS_EX2_IR: return TS_SH_IR;
                TS_EX1_IR, TS_PAU_IR:           return TS_PAU_IR;
                default:                        return TS_IDLE;
            endcase
        end
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drives one rising edge; mid is TDO just after the rising edge.
    task automatic tick(input logic m, input logic d, output logic mid);
        tms = m;
        tdi = d;
        @(posedge tck);
        mst = ref_next(mst, m);
        #1 mid = tdo;
        @(negedge tck);
        #1;
    endtask

    task automatic tk(input logic m, input logic d);
        logic unused_mid;
        tick(m, d, unused_mid);
    endtask

    function automatic int exp_sel(input logic [3:0] op);
        if (op == 4'b0000 || op == 4'b0010 || op == 4'b0100) return 2;
        if (op == 4'b0011) return 1;
        return 0;
    endfunction

    // From Run-Test/Idle: scan n bits of the data path; sel 0 bypass, 1 id, 2 boundary.
    task automatic dr_pass(input int sel, input int n, input logic [31:0] p, input logic [31:0] b);
        logic  m;
        logic  e;
        string rq;
        rq = (sel == 2) ? "R8" : (sel == 1) ? "R7" : "R6";
        tk(1'b1, 1'b0);
        bsr_so = b[0];
        tk(1'b0, 1'b0);
        check(bsr_cap == (sel == 2), "R8 capture strobe", 32'(bsr_cap), 32'(sel == 2));
        tk(1'b0, 1'b0);
        check(tdo_oe == 1'b1, "R10 oe in Shift-DR", 32'(tdo_oe), 32'd1);
        check(bsr_sh == (sel == 2), "R8 shift strobe", 32'(bsr_sh), 32'(sel == 2));
        for (int i = 0; i < n; i++) begin
            if (sel == 2)      e = b[i];
            else if (sel == 1) e = IDV[i];
            else               e = (i == 0) ? 1'b0 : p[i-1];
            check(tdo == e, rq, 32'(tdo), 32'(e));
            bsr_so = (i + 1 < n) ? b[i+1] : 1'b0;
            tick(i == n - 1, p[i], m);
            check(m == e, "R10 TDO held over rising edge", 32'(m), 32'(e));
        end
        check(tdo_oe == 1'b0, "R10 oe off in Exit1-DR", 32'(tdo_oe), 32'd0);
        tk(1'b1, 1'b0);
        check(bsr_upd == (sel == 2), "R8 update strobe", 32'(bsr_upd), 32'(sel == 2));
        tk(1'b0, 1'b0);
    endtask

    // From Run-Test/Idle: load an opcode and return to Run-Test/Idle.
    task automatic load_ir(input logic [3:0] op);
        logic nm;
        tk(1'b1, 1'b0);
        tk(1'b1, 1'b0);
        tk(1'b0, 1'b0);
        tk(1'b0, 1'b0);
        check(tdo_oe == 1'b1, "R10 oe in Shift-IR", 32'(tdo_oe), 32'd1);
        for (int i = 0; i < 4; i++) begin
            check(tdo == (i == 0), "R3 captured 0001", 32'(tdo), 32'(i == 0));
            tk(i == 3, op[i]);
        end
        check(mode == cur_mode, "R4 no change before update", 32'(mode), 32'(cur_mode));
        tk(1'b1, 1'b0);
        check(mode == cur_mode, "R4 no change entering Update-IR", 32'(mode), 32'(cur_mode));
        tk(1'b0, 1'b0);
        nm = (op == 4'b0000) || (op == 4'b0100);
        check(mode == nm, "R9 mode after update", 32'(mode), 32'(nm));
        cur_mode = nm;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        trst_n = 1'b0;
        #(CLK_P * 2);
        check(tdo_oe == 1'b0, "R2 oe off in reset", 32'(tdo_oe), 32'd0);
        check(mode == 1'b0, "R2 IDCODE active in reset", 32'(mode), 32'd0);
        @(negedge tck);
        #1 trst_n = 1'b1;
        mst = TS_RESET;

        tk(1'b1, 1'b0);
        tk(1'b1, 1'b0);
        check(tdo_oe == 1'b0, "R1 held in Test-Logic-Reset", 32'(tdo_oe), 32'd0);
        tk(1'b0, 1'b0);
        dr_pass(1, 32, 32'hA5C3_0F96, 32'h0);

        // R5 R9: every opcode, then the data path it selects
        for (int op = 0; op < 16; op++) begin
            load_ir(4'(op));
            dr_pass(exp_sel(4'(op)), 8, 32'(8'h6D ^ 8'(op * 29)), 32'(8'hB4 ^ 8'(op * 13)));
        end

        // R1 R10: pseudo-random TMS walk with periodic five-ones recovery
        lf = 16'hACE1;
        for (int s = 0; s < 600; s++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            tk(lf[0], lf[5]);
            check(tdo_oe == (mst == TS_SH_IR || mst == TS_SH_DR), "R10 oe vs state",
                  32'(tdo_oe), 32'(mst == TS_SH_IR || mst == TS_SH_DR));
            if (s % 100 == 99) begin
                for (int k = 0; k < 5; k++) tk(1'b1, lf[k]);
                check(tdo_oe == 1'b0, "R1 five ones reach reset", 32'(tdo_oe), 32'd0);
                tk(1'b0, 1'b0);
                check(mode == 1'b0, "R1 R4 IDCODE after reset", 32'(mode), 32'd0);
                cur_mode = 1'b0;
                dr_pass(1, 32, 32'h0, 32'h0);
                mst = TS_IDLE;
            end
        end

        // R2: asynchronous reset in the middle of Shift-DR under EXTEST
        for (int k = 0; k < 5; k++) tk(1'b1, 1'b0);
        tk(1'b0, 1'b0);
        cur_mode = 1'b0;
        load_ir(4'b0000);
        tk(1'b1, 1'b0);
        tk(1'b0, 1'b0);
        tk(1'b0, 1'b0);
        check(tdo_oe == 1'b1, "R10 oe in Shift-DR", 32'(tdo_oe), 32'd1);
        #2 trst_n = 1'b0;
        #1;
        check(tdo_oe == 1'b0, "R2 async oe off", 32'(tdo_oe), 32'd0);
        check(mode == 1'b0, "R2 async IDCODE", 32'(mode), 32'd0);
        mst = TS_RESET;
        cur_mode = 1'b0;
        @(negedge tck);
        #1 trst_n = 1'b1;
        tk(1'b0, 1'b0);
        dr_pass(1, 32, 32'h0F0F_3C3C, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule